// File: doc/BRIEF.md
# Multi-port cell FIFO read controller

The block holds four independent receive queues, each filled with fixed-size cells one 9-bit byte per write-clock cycle. A read-side agent chooses which queue to drain by presenting a 2-bit port number with a load strobe. The controller then streams the chosen port's oldest complete cell as 18-bit words on a separate read clock. Write and read clocks are unrelated. Each port's count of complete cells crosses into the read domain as a gray-coded value through a two-flop synchronizer. The count of released cells crosses back the same way.

The read side shows one ready flag per port. This flag drops one word early, so a poller can tell whether a further cell follows. A start strobe marks the first word of a cell, and a run signal falls four words before the cell ends as an early warning. A port choice is taken only between cells, never in the middle of a cell. The cell length, counted in words, is taken from configuration inputs while reset is held. A port that is already full discards the whole of any new cell.

Top module: `cell_rx_mux`

## Requirements
- R1: While reset is held and right after it is released, `rd_valid`, `cell_start`, `cell_run` and every bit of `cell_rdy` are low.
- R2: Each output word carries a cell's bytes in arrival order, the earlier byte in bits [17:9] and the later byte in bits [8:0], and a cell's words come out in order.
- R3: `cell_rdy[p]` rises at the second read-clock edge after the write-clock edge that took the last byte of a complete cell for port p.
- R4: When the selected port is idle and its flag is high, the first word appears with `cell_start` high after the next read edge. `cell_start` is high only on the first word.
- R5: `cell_rdy[p]` falls at the read edge that presents word N-2 of a cell of N words, unless port p holds another complete cell.
- R6: `cell_run` is high from the first word of a cell and is low from word N-4 (counting from 0) onward.
- R7: A load is accepted at any read edge with no transfer in progress, including the edge that ends the cycle after a cell's last word. The loaded port stays selected and is drained cell after cell until another load is accepted.
- R8: A load sampled while a cell is being transferred, including during the cycle that shows the last word, has no effect.
- R9: After the last word of a cell, `rd_valid` is low for at least one read cycle.
- R10: The cell length in words is taken while reset is held, as the 6-bit code {`size_b5`,`size_b4`,`size_lo[3:0]`} with `size_lo[0]` as the LSB. Codes below 5 are raised to 5. When `size_dflt` is high, the length is 27 words.
- R11: With the default queue depth of two cells, a cell whose first byte arrives while its port already holds two unread cells is dropped entirely. The stored cells come out unchanged and nothing extra follows them.
- R12: Loading a port that holds no complete cell selects it but produces no output until a cell for that port completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset, seen in both domains |
| wr_en | input | 4 | Per-port byte write strobe |
| wr_data | input | 36 | Per-port write bytes, port p in bits [9p+8:9p] |
| load_en | input | 1 | Load strobe for the port number |
| load_port | input | 2 | Port number to select |
| size_lo | input | 4 | Cell length code bits 3..0 |
| size_b4 | input | 1 | Cell length code bit 4 |
| size_b5 | input | 1 | Cell length code bit 5 |
| size_dflt | input | 1 | Selects the default cell length |
| rd_word | output | 18 | Output word |
| rd_valid | output | 1 | Output word is valid |
| cell_start | output | 1 | First word of a cell |
| cell_run | output | 1 | High until four words before the cell ends |
| cell_rdy | output | 4 | Per-port complete-cell flag |

## Verification
The bench drives both clocks from one source and samples on falling edges. Each result is therefore due at a fixed count of rising edges. A port's flag is expected two edges after the edge that took the last byte. The first word is expected one edge after the flag or an accepted load. The flag drop is expected on the word at index N-2, the run fall on the word at index N-4, and a low valid on the cycle after the last word. Load strobes are placed on exact cycles inside and just after a transfer, so that both the ignored window and the first accepting edge are checked.

// File: rtl/cfq_pkg.sv
package cfq_pkg;
  localparam int CNT_MAX_W  = 8;
  localparam int MIN_WORDS  = 5;
  localparam int DFLT_WORDS = 27;

  typedef logic [CNT_MAX_W-1:0] cnt_t;
  typedef logic [6:0]           words_t;

  function automatic cnt_t to_gray(cnt_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cnt_t from_gray(cnt_t g);
    cnt_t b;
    b[CNT_MAX_W-1] = g[CNT_MAX_W-1];
    for (int i = CNT_MAX_W-2; i >= 0; i--) b[i] = g[i] ^ b[i+1];
    return b;
  endfunction

  // Word count of one cell from the 6-bit code, clamped to [MIN_WORDS, max_words]
  function automatic words_t cell_words(logic [5:0] code, logic use_dflt, int max_words);
    int w;
    w = use_dflt ? DFLT_WORDS : int'(code);
    if (w < MIN_WORDS) w = MIN_WORDS;
    if (w > max_words) w = max_words;
    return words_t'(w);
  endfunction
endpackage

// File: rtl/cfq_sync.sv
module cfq_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/cfq_port.sv
module cfq_port
  import cfq_pkg::*;
#(
  parameter int BYTE_W    = 9,
  parameter int CELLS     = 2,
  parameter int MAX_WORDS = 63,
  parameter int SYNC      = 2,
  localparam int CW = $clog2(CELLS) + 1,
  localparam int SW = $clog2(CELLS),
  localparam int AW = $clog2(CELLS * MAX_WORDS),
  localparam int BW = $clog2(2 * MAX_WORDS)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  words_t            words_w,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              claim,
  input  logic              done,
  input  logic [AW-1:0]     rd_addr,
  output logic [2*BYTE_W-1:0] rd_data,
  output logic              avail,
  output logic [SW-1:0]     head_slot
);
  logic [2*BYTE_W-1:0] mem [CELLS*MAX_WORDS];

  // ---------------- write domain ----------------
  logic [BW-1:0]     byte_idx;
  logic [BYTE_W-1:0] hi_byte;
  logic              dropping;
  logic [CW-1:0]     wr_cells, wr_gray, done_gray_w, done_w;

  cfq_sync #(.W(CW), .STAGES(SYNC)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(done_gray_r), .q(done_gray_w));
  assign done_w = CW'(from_gray(cnt_t'(done_gray_w)));

  wire          first_byte = wr_en && (byte_idx == '0);
  wire          last_byte  = wr_en && (byte_idx == BW'(2 * int'(words_w) - 1));
  wire [CW-1:0] pending_w  = wr_cells - done_w;
  wire          port_full  = (pending_w == CW'(CELLS));
  wire          keep       = first_byte ? !port_full : !dropping;
  wire          commit     = last_byte && keep;
  wire [CW-1:0] wr_cells_nx = wr_cells + CW'(commit);
  wire [AW-1:0] wr_addr    = AW'(wr_cells[SW-1:0]) * AW'(MAX_WORDS) + AW'(byte_idx >> 1);

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      byte_idx <= '0;
      hi_byte  <= '0;
      dropping <= 1'b0;
      wr_cells <= '0;
      wr_gray  <= '0;
    end else begin
      if (wr_en) begin
        if (first_byte) dropping <= port_full;
        if (!byte_idx[0]) hi_byte <= wr_byte;
        byte_idx <= last_byte ? '0 : byte_idx + 1'b1;
      end
      wr_cells <= wr_cells_nx;
      wr_gray  <= CW'(to_gray(cnt_t'(wr_cells_nx)));
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en && byte_idx[0] && keep) mem[wr_addr] <= {hi_byte, wr_byte};
  end

  // ---------------- read domain ----------------
  logic [CW-1:0] wr_gray_r, wr_cells_r, claim_cnt, done_cnt, done_gray_r;
  wire  [CW-1:0] done_nx = done_cnt + CW'(done);

  cfq_sync #(.W(CW), .STAGES(SYNC)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_r));
  assign wr_cells_r = CW'(from_gray(cnt_t'(wr_gray_r)));

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      claim_cnt   <= '0;
      done_cnt    <= '0;
      done_gray_r <= '0;
    end else begin
      claim_cnt   <= claim_cnt + CW'(claim);
      done_cnt    <= done_nx;
      done_gray_r <= CW'(to_gray(cnt_t'(done_nx)));
    end
  end

  assign avail     = (wr_cells_r != claim_cnt);
  assign head_slot = claim_cnt[SW-1:0];
  assign rd_data   = mem[rd_addr];

  // R11: a port never holds more cells than its slots
  a_r11_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
    pending_w <= CW'(CELLS));
  // R11: a refused cell leaves the stored count alone on the next edge
  a_r11_drop_holds_count: assert property (@(posedge wclk) disable iff (!rst_n)
    (first_byte && port_full) |=> $stable(wr_cells));
  // R5: the read side only claims a cell that is present
  a_r5_claim_needs_cell: assert property (@(posedge rclk) disable iff (!rst_n)
    claim |-> avail);
endmodule

// File: rtl/cell_rx_mux.sv
module cell_rx_mux
  import cfq_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int BYTE_W    = 9,
  parameter int CELLS     = 2,
  parameter int MAX_WORDS = 63,
  parameter int SYNC      = 2,
  localparam int PW = $clog2(NPORTS),
  localparam int SW = $clog2(CELLS),
  localparam int AW = $clog2(CELLS * MAX_WORDS)
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        wr_en,
  input  logic [NPORTS*BYTE_W-1:0] wr_data,
  input  logic                     load_en,
  input  logic [PW-1:0]            load_port,
  input  logic [3:0]               size_lo,
  input  logic                     size_b4,
  input  logic                     size_b5,
  input  logic                     size_dflt,
  output logic [2*BYTE_W-1:0]      rd_word,
  output logic                     rd_valid,
  output logic                     cell_start,
  output logic                     cell_run,
  output logic [NPORTS-1:0]        cell_rdy
);
  words_t words_w, words_r;
  wire [5:0] size_code = {size_b5, size_b4, size_lo};

  // Cell length is taken while reset is held, in each domain
  always_ff @(posedge wclk) if (!rst_n) words_w <= cell_words(size_code, size_dflt, MAX_WORDS);
  always_ff @(posedge rclk) if (!rst_n) words_r <= cell_words(size_code, size_dflt, MAX_WORDS);

  logic [2*BYTE_W-1:0] port_data [NPORTS];
  logic [SW-1:0]       head_slot [NPORTS];
  logic [NPORTS-1:0]   claim_v, done_v;
  logic [AW-1:0]       rd_addr;

  generate
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
      cfq_port #(.BYTE_W(BYTE_W), .CELLS(CELLS), .MAX_WORDS(MAX_WORDS), .SYNC(SYNC)) u_port (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .words_w(words_w),
        .wr_en(wr_en[g]), .wr_byte(wr_data[g*BYTE_W +: BYTE_W]),
        .claim(claim_v[g]), .done(done_v[g]), .rd_addr(rd_addr),
        .rd_data(port_data[g]), .avail(cell_rdy[g]), .head_slot(head_slot[g]));
    end
  endgenerate

  // ---------------- read sequencer ----------------
  logic          xfer;
  logic [PW-1:0] sel;
  logic [SW-1:0] slot;
  words_t        widx;

  wire [PW-1:0] pick    = load_en ? load_port : sel;
  wire          start   = !xfer && cell_rdy[pick];
  wire [PW-1:0] cur     = xfer ? sel : pick;
  wire          word_go = start || (xfer && widx < words_r);
  wire words_t  idx     = xfer ? widx : '0;
  wire [SW-1:0] use_slot = xfer ? slot : head_slot[pick];
  wire          at_claim = xfer && (widx == words_r - 7'd2);
  wire          at_done  = xfer && (widx == words_r);

  assign rd_addr = AW'(use_slot) * AW'(MAX_WORDS) + AW'(idx);
  assign claim_v = at_claim ? (NPORTS'(1) << sel) : '0;
  assign done_v  = at_done  ? (NPORTS'(1) << sel) : '0;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      xfer       <= 1'b0;
      sel        <= '0;
      slot       <= '0;
      widx       <= '0;
      rd_word    <= '0;
      rd_valid   <= 1'b0;
      cell_start <= 1'b0;
      cell_run   <= 1'b0;
    end else begin
      if (!xfer && load_en) sel <= load_port;
      if (start) begin
        xfer <= 1'b1;
        slot <= head_slot[pick];
        widx <= 7'd1;
      end else if (xfer) begin
        widx <= widx + 7'd1;
        if (at_done) xfer <= 1'b0;
      end
      rd_valid   <= word_go;
      cell_start <= start;
      cell_run   <= word_go && (idx + 7'd4 < words_r);
      if (word_go) rd_word <= port_data[cur];
    end
  end

  // R6: the start strobe comes with a valid word and a high run signal
  a_r6_start_with_run: assert property (@(posedge rclk) disable iff (!rst_n)
    cell_start |-> (cell_run && rd_valid));
  // R8: the selection cannot move while a cell is in flight
  a_r8_sel_held: assert property (@(posedge rclk) disable iff (!rst_n)
    xfer |=> $stable(sel));
  // R9: the edge that closes a cell leaves a gap cycle
  a_r9_gap_after_cell: assert property (@(posedge rclk) disable iff (!rst_n)
    at_done |=> !rd_valid);
  // R5: at most one port claims a cell at a time
  a_r5_one_claim: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(claim_v));
endmodule

// File: tb/cell_rx_mux_test.sv
module cell_rx_mux_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr_en = '0;
  logic [35:0] wr_data = '0;
  logic        load_en = 1'b0;
  logic [1:0]  load_port = '0;
  logic [3:0]  size_lo = 4'd6;
  logic        size_b4 = 1'b0, size_b5 = 1'b0, size_dflt = 1'b0;
  logic [17:0] rd_word;
  logic        rd_valid, cell_start, cell_run;
  logic [3:0]  cell_rdy;

  int checks = 0;
  int fails  = 0;
  int n_words = 6;

  always #10 clk = ~clk;

  cell_rx_mux uut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .load_en(load_en), .load_port(load_port), .size_lo(size_lo), .size_b4(size_b4),
    .size_b5(size_b5), .size_dflt(size_dflt), .rd_word(rd_word), .rd_valid(rd_valid),
    .cell_start(cell_start), .cell_run(cell_run), .cell_rdy(cell_rdy));

  // {port, seed}: cell bytes are seed, seed+1, ...
  localparam logic [10:0] VEC [5] = '{
    {2'd0, 9'd10}, {2'd1, 9'd100}, {2'd3, 9'd200}, {2'd2, 9'd300}, {2'd0, 9'd400}};

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] exp_word(input int s, input int w);
    return {9'(s + 2*w), 9'(s + 2*w + 1)};
  endfunction

  task automatic write_cell(input int p, input int s, input int nbytes);
    for (int b = 0; b < nbytes; b++) begin
      @(negedge clk);
      wr_en = '0; wr_en[p] = 1'b1;
      wr_data = '0; wr_data[p*9 +: 9] = 9'(s + b);
    end
    @(negedge clk);
    wr_en = '0;
  endtask

  task automatic do_load(input int p);
    @(negedge clk);
    load_en = 1'b1; load_port = 2'(p);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic collect(input int p, input int s, input bit more);
    int guard = 0;
    while (!rd_valid && guard < 200) begin @(negedge clk); guard++; end
    if (!rd_valid) begin chk("R4", 0, 1); return; end
    for (int w = 0; w < n_words; w++) begin
      chk("R2", rd_word, exp_word(s, w));
      chk("R4", cell_start, w == 0);
      chk("R6", cell_run, w < n_words - 4);
      chk("R5", cell_rdy[p], more || (w < n_words - 2));
      @(negedge clk);
    end
    chk("R9", rd_valid, 0);
  endtask

  task automatic reset_with(input logic [3:0] lo, input logic b4, input logic dflt, input int nw);
    @(negedge clk);
    rst_n = 1'b0; size_lo = lo; size_b4 = b4; size_dflt = dflt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_words = nw;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {rd_valid, cell_start, cell_run}, 0);
    chk("R1", cell_rdy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {rd_valid, cell_start, cell_run, cell_rdy}, 0);

    // Table walk: load an empty port, then fill it and drain it (R12, R2..R6, R9)
    foreach (VEC[i]) begin
      do_load(int'(VEC[i][10:9]));
      repeat (2) @(negedge clk);
      chk("R12", rd_valid, 0);
      write_cell(int'(VEC[i][10:9]), int'(VEC[i][8:0]), 2*n_words);
      collect(int'(VEC[i][10:9]), int'(VEC[i][8:0]), 1'b0);
    end

    // R3/R4 exact flag and first-word timing on selected port 0
    write_cell(0, 30, 2*n_words);
    chk("R3", cell_rdy[0], 0);
    @(negedge clk);
    chk("R3", cell_rdy[0], 0);
    @(negedge clk);
    chk("R3", cell_rdy[0], 1);
    chk("R4", rd_valid, 0);
    @(negedge clk);
    chk("R4", {rd_valid, cell_start}, 2'b11);
    collect(0, 30, 1'b0);

    // R8: loads during a transfer are ignored
    do_load(1);
    write_cell(2, 60, 2*n_words);
    write_cell(1, 90, 2*n_words);
    fork
      collect(1, 90, 1'b0);
      begin
        wait (rd_valid);
        @(negedge clk); @(negedge clk);
        load_en = 1'b1; load_port = 2'd2;
        repeat (n_words - 1) @(negedge clk);
        load_en = 1'b0;
      end
    join
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R8", rd_valid, 0);
    end
    chk("R8", cell_rdy[2], 1);
    do_load(2);
    collect(2, 60, 1'b0);

    // R7: load taken in the cycle right after the last word
    do_load(0);
    write_cell(3, 130, 2*n_words);
    write_cell(0, 160, 2*n_words);
    fork
      collect(0, 160, 1'b0);
      begin
        wait (rd_valid);
        @(negedge clk);
        repeat (n_words) @(negedge clk);
        load_en = 1'b1; load_port = 2'd3;
        @(negedge clk);
        load_en = 1'b0;
        chk("R7", {rd_valid, cell_start}, 2'b11);
      end
    join
    collect(3, 130, 1'b0);

    // R11: third cell into a full port is dropped; R7 port stays selected
    do_load(1);
    write_cell(2, 20, 2*n_words);
    write_cell(2, 40, 2*n_words);
    write_cell(2, 70, 2*n_words);
    repeat (3) @(negedge clk);
    chk("R11", cell_rdy[2], 1);
    do_load(2);
    collect(2, 20, 1'b1);
    collect(2, 40, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R11", rd_valid, 0);
    end
    chk("R11", cell_rdy[2], 0);

    // R10: cell length codes
    reset_with(4'd3, 1'b0, 1'b0, 5);
    @(negedge clk);
    chk("R1", {rd_valid, cell_rdy}, 0);
    write_cell(0, 50, 10);
    collect(0, 50, 1'b0);
    chk("R10", cell_rdy[0], 0);

    reset_with(4'd2, 1'b1, 1'b0, 18);
    write_cell(0, 120, 36);
    collect(0, 120, 1'b0);
    chk("R10", rd_valid, 0);

    reset_with(4'd9, 1'b0, 1'b1, 27);
    write_cell(0, 300, 54);
    collect(0, 300, 1'b0);
    chk("R10", rd_valid, 0);

    report();
  end
endmodule